// File: doc/BRIEF.md
# Instruction Cycle Sequencer

This block is the multi-cycle control unit of a small accumulator machine. It walks every instruction through a fetch phase, an indirect-address phase when the instruction asks for one, an execute phase, and an interrupt phase when a request is pending and interrupts are enabled. Four internal registers carry the data: the program counter, the memory address register, the memory buffer register and the instruction register. The accumulator and the interrupt-enable flag make up the rest of the machine state.

All traffic goes over one memory port. The port has a registered address, a read strobe, a write strobe, write data, and read data qualified by a ready input. Each access holds until ready is seen. The address bus is driven straight from the memory address register, and the write data straight from the memory buffer register. The accumulator, the program counter, the enable flag and a two-bit phase code are brought out so that the surrounding logic can follow execution.

The interrupt save location and the vector address are fixed parameters. A handler can return by jumping indirectly through the save location.

Top module: `instr_cycle_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the program counter is 0, the accumulator is 0, the enable flag is 0, the phase is fetch (0), and neither strobe is high.
- R2: Every instruction begins with a read at the program counter. The returned word becomes the instruction. On that handshake the program counter advances by one, modulo 2^11.
- R3: An instruction word holds the opcode in bits 15..12, the indirect flag in bit 11 and the address field in bits 10..0. The opcodes are load=1, store=2, add=3, jump=4, enable-interrupts=5 and disable-interrupts=6. Every other opcode leaves the machine state unchanged.
- R4: For opcodes 1 to 4 with bit 11 set, one extra read is made at the address field, in phase 1 (indirect). The low 11 bits of the returned word become the effective address.
- R5: For opcodes other than 1 to 4, bit 11 is ignored and no indirect read takes place.
- R6: Load reads the effective address into the accumulator. Add reads the effective address and adds the word to the accumulator, modulo 2^16. Both reads take place in phase 2 (execute).
- R7: Store writes the accumulator to the effective address in phase 2.
- R8: Jump loads the effective address into the program counter and makes no execute-phase access.
- R9: Opcodes 5 and 6 set and clear the enable flag. The new value already governs the interrupt decision at the end of that same instruction.
- R10: After execute, if the enable flag and the request input are both high, the sequencer writes the program counter (zero-extended) to the save address in phase 3 (interrupt). It then loads the vector address into the program counter and clears the enable flag. Otherwise the next fetch follows.
- R11: A read or write that is not acknowledged by ready is presented again in the next cycle, with the same address and write data.
- R12: Read and write are never high together. The phases run in the order fetch, optional indirect, execute, optional interrupt, fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 11 | Memory address (memory address register) |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 16 | Write data (memory buffer register) |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current access |
| irq | input | 1 | Interrupt request, level |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 11 | Program counter |
| ie_o | output | 1 | Interrupt-enable flag |
| phase_o | output | 2 | 0 fetch, 1 indirect, 2 execute, 3 interrupt |

## Verification
A corrupted state register or a wrong branch in the sequencer shows up at the memory port on the very next handshake. It appears as an access at the wrong address, in the wrong phase, or in the wrong direction, and a skipped or extra indirect read shifts every later access. A wrong accumulator, program counter or enable flag is seen at the next fetch handshake, where the visible state is compared with an instruction-level model. A bad accumulator also reaches the data of the next store. A wrong interrupt decision surfaces within one instruction, either as a missing or extra write to the save address, or as the fetch that follows going to the wrong place.

// File: rtl/icsq_pkg.sv
package icsq_pkg;

    typedef enum logic [3:0] {
        ST_F_ADDR    = 4'd0,
        ST_F_READ    = 4'd1,
        ST_F_LOAD    = 4'd2,
        ST_I_READ    = 4'd3,
        ST_I_LOAD    = 4'd4,
        ST_X_DISP    = 4'd5,
        ST_X_READ    = 4'd6,
        ST_X_ALU     = 4'd7,
        ST_X_WRITE   = 4'd8,
        ST_INT_SETUP = 4'd9,
        ST_INT_WRITE = 4'd10
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_FETCH     = 2'd0,
        PH_INDIRECT  = 2'd1,
        PH_EXECUTE   = 2'd2,
        PH_INTERRUPT = 2'd3
    } phase_e;

    localparam logic [3:0] OPC_LOAD  = 4'd1;
    localparam logic [3:0] OPC_STORE = 4'd2;
    localparam logic [3:0] OPC_ADD   = 4'd3;
    localparam logic [3:0] OPC_JUMP  = 4'd4;
    localparam logic [3:0] OPC_IEN   = 4'd5;
    localparam logic [3:0] OPC_IDIS  = 4'd6;

    typedef struct packed {
        logic mem_ref;
        logic is_load;
        logic is_add;
        logic is_store;
        logic is_jump;
        logic set_ie;
        logic clr_ie;
    } op_class_t;

endpackage

// File: rtl/icsq_decode.sv
module icsq_decode
    import icsq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4
) (
    input  logic [DATA_W-1:0] word_i,
    output op_class_t         cls_o,
    output logic              ind_o
);
    localparam int OPC_LSB = DATA_W - OPC_W;
    localparam int IND_BIT = OPC_LSB - 1;

    logic [OPC_W-1:0] opc;
    assign opc = word_i[DATA_W-1:OPC_LSB];

    always_comb begin
        cls_o = '0;
        case (opc)
            OPC_W'(OPC_LOAD):  begin cls_o.mem_ref = 1'b1; cls_o.is_load  = 1'b1; end
            OPC_W'(OPC_STORE): begin cls_o.mem_ref = 1'b1; cls_o.is_store = 1'b1; end
            OPC_W'(OPC_ADD):   begin cls_o.mem_ref = 1'b1; cls_o.is_add   = 1'b1; end
            OPC_W'(OPC_JUMP):  begin cls_o.mem_ref = 1'b1; cls_o.is_jump  = 1'b1; end
            OPC_W'(OPC_IEN):   cls_o.set_ie = 1'b1;
            OPC_W'(OPC_IDIS):  cls_o.clr_ie = 1'b1;
            default:           ;
        endcase
    end

    // the indirect flag only matters for memory-referencing opcodes
    assign ind_o = word_i[IND_BIT] & cls_o.mem_ref;

endmodule

// File: rtl/icsq_alu.sv
module icsq_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              add_i,
    output logic [DATA_W-1:0] acc_o
);
    assign acc_o = add_i ? (acc_i + operand_i) : operand_i;
endmodule

// File: rtl/icsq_strobe.sv
module icsq_strobe
    import icsq_pkg::*;
(
    input  seq_state_e  state_i,
    output logic        rd_o,
    output logic        wr_o,
    output logic [1:0]  phase_o
);
    always_comb begin
        rd_o    = 1'b0;
        wr_o    = 1'b0;
        phase_o = PH_FETCH;
        case (state_i)
            ST_F_ADDR, ST_F_LOAD: ;
            ST_F_READ:    rd_o = 1'b1;
            ST_I_READ:    begin rd_o = 1'b1; phase_o = PH_INDIRECT; end
            ST_I_LOAD:    phase_o = PH_INDIRECT;
            ST_X_DISP,
            ST_X_ALU:     phase_o = PH_EXECUTE;
            ST_X_READ:    begin rd_o = 1'b1; phase_o = PH_EXECUTE; end
            ST_X_WRITE:   begin wr_o = 1'b1; phase_o = PH_EXECUTE; end
            ST_INT_SETUP: phase_o = PH_INTERRUPT;
            ST_INT_WRITE: begin wr_o = 1'b1; phase_o = PH_INTERRUPT; end
            default:      ;
        endcase
    end
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
    import icsq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 11,
    parameter int OPC_W     = 4,
    parameter int RESET_PC  = 0,
    parameter int SAVE_ADDR = 'h0FF,
    parameter int VEC_ADDR  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              irq,
    output logic [DATA_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              ie_o,
    output logic [1:0]        phase_o
);
    localparam logic [ADDR_W-1:0] PC_INIT  = ADDR_W'(RESET_PC);
    localparam logic [ADDR_W-1:0] SAVE_LOC = ADDR_W'(SAVE_ADDR);
    localparam logic [ADDR_W-1:0] VEC_LOC  = ADDR_W'(VEC_ADDR);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic              ie;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [DATA_W-1:0] dec_word;
    op_class_t         cls;
    logic              ind;
    logic [DATA_W-1:0] alu_res;
    logic              instr_done;

    // the word is decoded from MBR in the cycle that copies it into IR
    assign dec_word = (r_q.st == ST_F_LOAD) ? r_q.mbr : r_q.ir;

    icsq_decode #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_decode (
        .word_i (dec_word),
        .cls_o  (cls),
        .ind_o  (ind)
    );

    icsq_alu #(.DATA_W(DATA_W)) u_alu (
        .acc_i     (r_q.acc),
        .operand_i (r_q.mbr),
        .add_i     (cls.is_add),
        .acc_o     (alu_res)
    );

    icsq_strobe u_strobe (
        .state_i (r_q.st),
        .rd_o    (mem_rd),
        .wr_o    (mem_wr),
        .phase_o (phase_o)
    );

    always_comb begin
        r_d        = r_q;
        instr_done = 1'b0;
        case (r_q.st)
            ST_F_ADDR: begin
                r_d.mar = r_q.pc;
                r_d.st  = ST_F_READ;
            end
            ST_F_READ: begin
                if (mem_ready) begin
                    r_d.mbr = mem_rdata;
                    r_d.pc  = r_q.pc + 1'b1;
                    r_d.st  = ST_F_LOAD;
                end
            end
            ST_F_LOAD: begin
                r_d.ir  = r_q.mbr;
                r_d.mar = r_q.mbr[ADDR_W-1:0];
                r_d.st  = ind ? ST_I_READ : ST_X_DISP;
            end
            ST_I_READ: begin
                if (mem_ready) begin
                    r_d.mbr = mem_rdata;
                    r_d.st  = ST_I_LOAD;
                end
            end
            ST_I_LOAD: begin
                r_d.mar = r_q.mbr[ADDR_W-1:0];
                r_d.st  = ST_X_DISP;
            end
            ST_X_DISP: begin
                if (cls.is_load || cls.is_add) begin
                    r_d.st = ST_X_READ;
                end else if (cls.is_store) begin
                    r_d.mbr = r_q.acc;
                    r_d.st  = ST_X_WRITE;
                end else begin
                    if (cls.is_jump) r_d.pc = r_q.mar;
                    if (cls.set_ie)  r_d.ie = 1'b1;
                    if (cls.clr_ie)  r_d.ie = 1'b0;
                    instr_done = 1'b1;
                end
            end
            ST_X_READ: begin
                if (mem_ready) begin
                    r_d.mbr = mem_rdata;
                    r_d.st  = ST_X_ALU;
                end
            end
            ST_X_ALU: begin
                r_d.acc    = alu_res;
                instr_done = 1'b1;
            end
            ST_X_WRITE: begin
                if (mem_ready) instr_done = 1'b1;
            end
            ST_INT_SETUP: begin
                r_d.mbr = DATA_W'(r_q.pc);
                r_d.mar = SAVE_LOC;
                r_d.ie  = 1'b0;
                r_d.st  = ST_INT_WRITE;
            end
            ST_INT_WRITE: begin
                if (mem_ready) begin
                    r_d.pc = VEC_LOC;
                    r_d.st = ST_F_ADDR;
                end
            end
            default: r_d.st = ST_F_ADDR;
        endcase
        // interrupt decision uses the flag as left by this instruction
        if (instr_done) begin
            r_d.st = (r_d.ie && irq) ? ST_INT_SETUP : ST_F_ADDR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_F_ADDR;
            r_q.pc  <= PC_INIT;
            r_q.mar <= '0;
            r_q.mbr <= '0;
            r_q.ir  <= '0;
            r_q.acc <= '0;
            r_q.ie  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_wdata = r_q.mbr;
    assign acc_o     = r_q.acc;
    assign pc_o      = r_q.pc;
    assign ie_o      = r_q.ie;

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready && phase_o == PH_FETCH) |=>
            (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

    // R10
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ready && phase_o == PH_INTERRUPT) |=>
            (pc_o == VEC_LOC && !ie_o && phase_o == PH_FETCH));

    // R9
    ie_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie_o) |-> ($past(phase_o) == PH_EXECUTE));

    // R12
    ind_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_INDIRECT) |=> (phase_o inside {PH_INDIRECT, PH_EXECUTE}));

    // R12
    int_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_INTERRUPT) |=> (phase_o inside {PH_INTERRUPT, PH_FETCH}));

    // R7
    wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (phase_o inside {PH_EXECUTE, PH_INTERRUPT}));

endmodule

// File: tb/instr_cycle_seq_bench.sv
module instr_cycle_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int AW         = 11;
    localparam int MEM_WORDS  = 1 << AW;
    localparam int SAVE       = 'h0FF;
    localparam int VEC        = 'h100;
    localparam int MAX_INSTR  = 500;
    localparam int WATCHDOG   = 100000;
    localparam int IRQ_GAP    = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_ready = 1'b0;
    logic          irq = 1'b0;
    logic [DW-1:0] acc_o;
    logic [AW-1:0] pc_o;
    logic          ie_o;
    logic [1:0]    phase_o;

    logic [DW-1:0] mem [0:MEM_WORDS-1];
    assign mem_rdata = mem[mem_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_cycle_seq u_instr_cycle_seq (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq),
        .acc_o(acc_o), .pc_o(pc_o), .ie_o(ie_o), .phase_o(phase_o)
    );

    typedef struct {
        bit    wr;
        int    addr;
        int    data;
        int    phase;
        string tag;
    } txn_t;

    txn_t  q[$];
    int    n_chk = 0, n_fail = 0;
    int    m_pc = 0, m_acc = 0, m_ie = 0;
    int    n_instr = 0, n_int = 0, n_blk = 0, n_ind = 0;
    int    cyc_cnt = 0, fetch_cnt = 0, next_raise = 3, stall_cnt = 0;
    bit    running = 0, done = 0, drop_pending = 0;
    bit    prev_rd = 0, prev_wr = 0, prev_ready = 0;
    int    prev_addr = 0, prev_wdata = 0;
    string pend_tag = "R2";
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic txn_t mk(input bit wr, input int addr, input int data,
                                input int phase, input string tag);
        txn_t t;
        t.wr = wr; t.addr = addr; t.data = data; t.phase = phase; t.tag = tag;
        return t;
    endfunction

    function automatic logic [15:0] ins(input int op, input int ind, input int a);
        return {4'(op), 1'(ind), 11'(a)};
    endfunction

    // instruction-level reference: expected accesses of one instruction
    task automatic model_step(input bit irq_now);
        int  w, opc, ea;
        bit  ind, mref;
        w = int'(mem[m_pc]);
        q.push_back(mk(0, m_pc, 0, 0, pend_tag));
        pend_tag = "R2";
        m_pc = (m_pc + 1) % MEM_WORDS;
        // R3: opcode in 15..12, indirect flag in 11, address in 10..0
        opc  = (w >> 12) & 15;
        ind  = ((w >> 11) & 1) == 1;
        ea   = w & (MEM_WORDS - 1);
        mref = (opc >= 1 && opc <= 4);
        if (mref && ind) begin
            q.push_back(mk(0, ea, 0, 1, "R4"));
            ea = int'(mem[ea]) & (MEM_WORDS - 1);
            n_ind++;
        end else if (ind) begin
            pend_tag = "R5";
        end
        case (opc)
            1: begin q.push_back(mk(0, ea, 0, 2, "R6")); m_acc = int'(mem[ea]); end
            3: begin q.push_back(mk(0, ea, 0, 2, "R6")); m_acc = (m_acc + int'(mem[ea])) & 'hFFFF; end
            2: q.push_back(mk(1, ea, m_acc, 2, "R7"));
            4: m_pc = ea;
            5: m_ie = 1;
            6: m_ie = 0;
            default: ;
        endcase
        if (irq_now) begin
            if (m_ie == 1) begin
                q.push_back(mk(1, SAVE, m_pc, 3, "R10"));
                m_pc = VEC;
                m_ie = 0;
                n_int++;
            end else begin
                n_blk++;
            end
        end
        n_instr++;
    endtask

    always @(negedge clk) begin
        if (running && !done) begin
            txn_t t;
            cyc_cnt++;
            if (cyc_cnt > WATCHDOG) begin
                check(0, "R12", "watchdog expired", cyc_cnt, WATCHDOG);
                done = 1;
            end else if (n_instr >= MAX_INSTR && q.size() == 0) begin
                done = 1;
            end else begin
                // memory ready pattern with occasional long stalls
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                if (stall_cnt > 0) begin
                    stall_cnt--;
                    mem_ready = 1'b0;
                end else if (lfsr[6:2] == 5'd0) begin
                    stall_cnt = 5;
                    mem_ready = 1'b0;
                end else begin
                    mem_ready = (lfsr[1:0] != 2'b00);
                end
                // request changes only while a fetch read is pending
                if (mem_rd && phase_o == 2'd0) begin
                    if (drop_pending) begin
                        irq = 1'b0;
                        drop_pending = 0;
                    end else if (!irq && fetch_cnt >= next_raise) begin
                        irq = 1'b1;
                        next_raise = fetch_cnt + IRQ_GAP;
                    end
                end
                // R12: never both strobes
                check(!(mem_rd && mem_wr), "R12", "rd and wr together", {mem_rd, mem_wr}, 0);
                // R11: unacknowledged access is held
                if (prev_rd && !prev_ready)
                    check(mem_rd && int'(mem_addr) == prev_addr, "R11", "read not held",
                          mem_addr, prev_addr);
                if (prev_wr && !prev_ready)
                    check(mem_wr && int'(mem_addr) == prev_addr && int'(mem_wdata) == prev_wdata,
                          "R11", "write not held", mem_wdata, prev_wdata);
                if ((mem_rd || mem_wr) && mem_ready) begin
                    if (mem_rd && phase_o == 2'd0 && q.size() == 0) begin
                        check(int'(acc_o) == m_acc, "R3/R6", "acc at boundary", acc_o, m_acc);
                        check(int'(ie_o) == m_ie, "R9", "enable flag at boundary", ie_o, m_ie);
                        check(int'(pc_o) == m_pc, "R3/R8", "pc at boundary", pc_o, m_pc);
                        model_step(irq);
                        fetch_cnt++;
                    end
                    if (q.size() == 0) begin
                        check(0, "R12", "unexpected access", mem_addr, 0);
                    end else begin
                        t = q.pop_front();
                        check(mem_wr == t.wr && int'(mem_addr) == t.addr && int'(phase_o) == t.phase,
                              t.tag, "access addr/dir/phase",
                              {mem_wr, phase_o, mem_addr}, {t.wr, 2'(t.phase), 11'(t.addr)});
                        if (t.wr)
                            check(int'(mem_wdata) == t.data, t.tag, "write data", mem_wdata, t.data);
                        if (t.phase == 3) drop_pending = 1;
                    end
                    if (mem_wr) mem[mem_addr] = mem_wdata;
                end
                prev_rd    = mem_rd;
                prev_wr    = mem_wr;
                prev_ready = mem_ready;
                prev_addr  = int'(mem_addr);
                prev_wdata = int'(mem_wdata);
            end
        end
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        // main program
        mem['h000] = ins(1, 0, 'h200);   // load 7FFF
        mem['h001] = ins(3, 0, 'h201);   // add 8002 -> wraps to 0001
        mem['h002] = ins(3, 1, 'h202);   // add indirect -> +5
        mem['h003] = ins(2, 0, 'h210);   // store
        mem['h004] = ins(2, 1, 'h204);   // store indirect to 211
        mem['h005] = ins(0, 1, 'h205);   // no-op with flag set
        mem['h006] = ins(5, 0, 0);       // enable
        mem['h007] = ins(3, 0, 'h205);   // add 1
        mem['h008] = ins(6, 0, 0);       // disable
        mem['h009] = ins(3, 0, 'h205);
        mem['h00A] = ins(5, 0, 0);
        mem['h00B] = ins(4, 1, 'h206);   // jump indirect to 7FF
        mem['h00C] = ins(2, 0, 'h212);
        mem['h00D] = ins(4, 0, 'h007);
        mem['h7FF] = ins(4, 0, 'h00C);   // pc wraps on this fetch
        // handler
        mem['h100] = ins(2, 0, 'h213);
        mem['h101] = ins(5, 0, 0);
        mem['h102] = ins(4, 1, SAVE);    // return through save slot
        // data
        mem['h200] = 16'h7FFF;
        mem['h201] = 16'h8002;
        mem['h202] = 16'h0203;
        mem['h203] = 16'h0005;
        mem['h204] = 16'h0211;
        mem['h205] = 16'h0001;
        mem['h206] = 16'h07FF;

        repeat (3) @(negedge clk);
        // R1: state held in reset
        check(pc_o == 0 && acc_o == 0 && ie_o == 0, "R1", "state in reset", {pc_o, acc_o, ie_o}, 0);
        check(!mem_rd && !mem_wr && phase_o == 0, "R1", "strobes in reset", {mem_rd, mem_wr, phase_o}, 0);
        rst_n = 1'b1;
        #1;
        check(pc_o == 0 && acc_o == 0 && ie_o == 0, "R1", "state after release", {pc_o, acc_o, ie_o}, 0);
        check(!mem_rd && !mem_wr && phase_o == 0, "R1", "strobes after release", {mem_rd, mem_wr, phase_o}, 0);
        running = 1;
        wait (done);
        check(n_ind > 0, "R4", "indirect cycles seen", n_ind, 1);
        check(n_int > 0, "R10", "interrupts taken", n_int, 1);
        check(n_blk > 0, "R9", "requests held off while disabled", n_blk, 1);
        check(int'(mem['h211]) == 6, "R7", "indirect store result", mem['h211], 6);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule